// File: doc/BRIEF.md
# Reset-Type Strap Latch Controller

This block turns four external reset requests into per-domain reset outputs for a small processor subsystem. It also records the boot straps for the boot software. The four requests are a cold power-on request, a full warm request, a configurable request that can run as hard or soft, and a local request that reaches the core alone. Each reset kind follows its own rule on three points: which domains it clears, whether it samples the 13 bootstrap pins again, and whether the boot sequence runs once the core is free.

Every domain reset goes low asynchronously as soon as a request that covers that domain appears. Each domain is released through its own synchronizer on the system clock. The strap word is held in a status register, which reloads only while a power-on or full reset holds the strap-capture domain. The register is split into a boot-device code, a mode-specific configuration field and an upper field. The upper field selects a PLL setting, except for the two serial-EEPROM/flash boot devices, which use it as extended configuration and run with the PLL bypassed. A single-cycle start-boot pulse follows the release of the core reset, but only when a kind that starts boot was part of the reset.

Top module: `rst_strap_ctrl`

## Requirements
- R1: A power-on request clears all five domains (core, peripheral, configuration-register, debug, isolated peripheral), loads the strap pins into `strap_word`, and gives one start-boot pulse after release.
- R2: A full warm request has the same effect as power-on: all five domains, strap reload, one boot pulse.
- R3: A configurable request with `cfg_soft`=0 clears core, peripheral and configuration-register domains only. The debug and isolated domains stay out of reset, `strap_word` keeps its old value, and one boot pulse follows.
- R4: A configurable request with `cfg_soft`=1 clears only core and peripheral domains, leaves `strap_word` unchanged, and gives one boot pulse.
- R5: A local request clears only the core domain, leaves `strap_word` unchanged and gives no boot pulse.
- R6: A domain reset output goes low with no clock edge once a covering request rises. After the last covering request falls, the output goes high on the second rising clock edge (SYNC_STAGES=2).
- R7: `boot_start` is high for exactly one clock cycle, starting at the rising edge that follows the edge that released `rst_core_n`.
- R8: Simultaneous requests act as the broadest of them, in the priority order power-on, full, configurable, local. The boot pulse waits until the core reset is released, even if a narrower request still holds the core after the broader one ends.
- R9: `boot_dev` equals `strap_word[2:0]` and `dev_cfg` equals `strap_word[9:3]`. `boot_dev_oh` has exactly bit `boot_dev` set (0 sleep/NOR, 1 RapidIO, 2 and 3 Ethernet, 4 PCIe, 5 I2C, 6 SPI, 7 chip-to-chip link).
- R10: For boot-device codes 5 and 6, `pll_bypass`=1, `ext_cfg`=`strap_word[12:10]` and `pll_sel`=0. For all other codes, `pll_bypass`=0, `pll_sel`=`strap_word[12:10]` and `ext_cfg`=0.
- R11: Changes on `strap_pins` while no power-on or full request is in progress have no effect on `strap_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| req_por | input | 1 | Power-on reset request, active high |
| req_full | input | 1 | Full warm reset request, active high |
| req_cfg | input | 1 | Configurable reset request, active high |
| cfg_soft | input | 1 | Selects soft mode for the configurable request |
| req_local | input | 1 | Core-only reset request, active high |
| strap_pins | input | 13 | Bootstrap pin bus |
| rst_core_n | output | 1 | Core domain reset, active low |
| rst_periph_n | output | 1 | Peripheral domain reset, active low |
| rst_mmr_n | output | 1 | Configuration-register domain reset (PCIe, external memory, DDR registers), active low |
| rst_dbg_n | output | 1 | Debug/emulation domain reset, active low |
| rst_iso_n | output | 1 | Reset-isolated peripheral domain reset, active low; also the strap-capture window |
| boot_start | output | 1 | One-cycle start-boot pulse |
| strap_word | output | 13 | Latched strap status word |
| boot_dev | output | 3 | Boot-device code |
| boot_dev_oh | output | 8 | One-hot boot device |
| dev_cfg | output | 7 | Boot-mode specific configuration |
| pll_sel | output | 3 | PLL setting select |
| ext_cfg | output | 3 | Extended device configuration |
| pll_bypass | output | 1 | PLL bypassed for the serial boot devices |

## Verification
The bench drives each reset kind with new strap values on the pins, so a design that reloads the straps on a configurable or local reset shows a changed status word. It overlaps a power-on request with a local one and releases the power-on first. A design that fires the boot pulse before the core reset is free, or drops it because the winning kind has already ended, is caught there. Combined configurable-plus-local and full-plus-configurable requests expose a wrong priority mask. Cycle-exact sampling around release catches a synchronizer with the wrong depth and a boot pulse that is late or longer than one cycle. Strap values that put codes 4, 5, 6, 7 and 0 on the device field check the PLL/extended-field switch.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   localparam int DOM_CORE   = 0;
   localparam int DOM_PERIPH = 1;
   localparam int DOM_MMR    = 2;
   localparam int DOM_DBG    = 3;
   localparam int DOM_ISO    = 4;
   localparam int NUM_DOM    = 5;

   typedef logic [NUM_DOM-1:0] dom_vec_t;

   // ordered from narrowest to broadest
   typedef enum logic [2:0] {
      KIND_NONE     = 3'd0,
      KIND_LOCAL    = 3'd1,
      KIND_CFG_SOFT = 3'd2,
      KIND_CFG_HARD = 3'd3,
      KIND_FULL     = 3'd4,
      KIND_POR      = 3'd5
   } rst_kind_e;

   function automatic dom_vec_t kind_mask(rst_kind_e k);
      dom_vec_t m;
      m = '0;
      case (k)
         KIND_LOCAL:    m[DOM_CORE] = 1'b1;
         KIND_CFG_SOFT: begin
            m[DOM_CORE]   = 1'b1;
            m[DOM_PERIPH] = 1'b1;
         end
         KIND_CFG_HARD: begin
            m[DOM_CORE]   = 1'b1;
            m[DOM_PERIPH] = 1'b1;
            m[DOM_MMR]    = 1'b1;
         end
         KIND_FULL, KIND_POR: m = '1;
         default: m = '0;
      endcase
      return m;
   endfunction

   function automatic logic kind_boots(rst_kind_e k);
      return (k == KIND_CFG_SOFT) || (k == KIND_CFG_HARD) ||
             (k == KIND_FULL) || (k == KIND_POR);
   endfunction

   function automatic logic kind_latches(rst_kind_e k);
      return (k == KIND_FULL) || (k == KIND_POR);
   endfunction

endpackage

// File: rtl/rsc_kind_enc.sv
module rsc_kind_enc
   import rsc_pkg::*;
(
   input  logic      req_por,
   input  logic      req_full,
   input  logic      req_cfg,
   input  logic      cfg_soft,
   input  logic      req_local,
   output rst_kind_e kind,
   output dom_vec_t  dom_req,
   output logic      boot_req
);

   always_comb begin
      if (req_por)        kind = KIND_POR;
      else if (req_full)  kind = KIND_FULL;
      else if (req_cfg)   kind = cfg_soft ? KIND_CFG_SOFT : KIND_CFG_HARD;
      else if (req_local) kind = KIND_LOCAL;
      else                kind = KIND_NONE;
   end

   assign dom_req  = kind_mask(kind);
   assign boot_req = kind_boots(kind);

endmodule

// File: rtl/rsc_rst_sync.sv
module rsc_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   output logic rst_n_o
);

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) chain <= '0;
      else     chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign rst_n_o = chain[STAGES-1];

endmodule

// File: rtl/rsc_boot_seq.sv
module rsc_boot_seq (
   input  logic clk,
   input  logic boot_req,
   input  logic core_req,
   input  logic core_rst_n,
   output logic boot_start
);

   logic pending;

   // remembers that a boot-starting kind took part in the reset
   always_ff @(posedge clk or posedge boot_req) begin
      if (boot_req)                    pending <= 1'b1;
      else if (pending && core_rst_n)  pending <= 1'b0;
   end

   always_ff @(posedge clk or posedge core_req) begin
      if (core_req) boot_start <= 1'b0;
      else          boot_start <= pending && core_rst_n;
   end

endmodule

// File: rtl/rsc_strap.sv
module rsc_strap #(
   parameter int STRAP_W = 13,
   parameter int DEV_W   = 3,
   parameter int CFG_W   = 7,
   parameter int XTRA_W  = 3,
   parameter int EXT_A   = 5,
   parameter int EXT_B   = 6
) (
   input  logic                 clk,
   input  logic                 cap_n,
   input  logic [STRAP_W-1:0]   pins,
   output logic [STRAP_W-1:0]   word,
   output logic [DEV_W-1:0]     dev,
   output logic [(1<<DEV_W)-1:0] dev_oh,
   output logic [CFG_W-1:0]     cfg,
   output logic [XTRA_W-1:0]    pll,
   output logic [XTRA_W-1:0]    ext,
   output logic                 bypass
);

   localparam int CFG_LO  = DEV_W;
   localparam int XTRA_LO = DEV_W + CFG_W;
   localparam int NDEV    = 1 << DEV_W;

   logic [XTRA_W-1:0] upper;

   // loads every cycle while the capture window is held, freezes on release
   always_ff @(posedge clk) begin
      if (!cap_n) word <= pins;
   end

   assign dev   = word[DEV_W-1:0];
   assign cfg   = word[CFG_LO +: CFG_W];
   assign upper = word[XTRA_LO +: XTRA_W];

   for (genvar i = 0; i < NDEV; i++) begin : g_oh
      assign dev_oh[i] = (dev == DEV_W'(i));
   end

   assign bypass = (dev == DEV_W'(EXT_A)) || (dev == DEV_W'(EXT_B));
   assign pll    = bypass ? '0 : upper;
   assign ext    = bypass ? upper : '0;

endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
   import rsc_pkg::*;
#(
   parameter int STRAP_W     = 13,
   parameter int DEV_W       = 3,
   parameter int CFG_W       = 7,
   parameter int XTRA_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_A       = 5,
   parameter int EXT_B       = 6
) (
   input  logic                    clk,
   input  logic                    req_por,
   input  logic                    req_full,
   input  logic                    req_cfg,
   input  logic                    cfg_soft,
   input  logic                    req_local,
   input  logic [STRAP_W-1:0]      strap_pins,
   output logic                    rst_core_n,
   output logic                    rst_periph_n,
   output logic                    rst_mmr_n,
   output logic                    rst_dbg_n,
   output logic                    rst_iso_n,
   output logic                    boot_start,
   output logic [STRAP_W-1:0]      strap_word,
   output logic [DEV_W-1:0]        boot_dev,
   output logic [(1<<DEV_W)-1:0]   boot_dev_oh,
   output logic [CFG_W-1:0]        dev_cfg,
   output logic [XTRA_W-1:0]       pll_sel,
   output logic [XTRA_W-1:0]       ext_cfg,
   output logic                    pll_bypass
);

   if (STRAP_W != DEV_W + CFG_W + XTRA_W) begin : g_err_width
      $error("strap fields do not add up to STRAP_W");
   end
   if (SYNC_STAGES < 2) begin : g_err_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (EXT_A >= (1 << DEV_W) || EXT_B >= (1 << DEV_W)) begin : g_err_code
      $error("extended-config device codes exceed DEV_W");
   end

   rst_kind_e kind;
   dom_vec_t  dom_req;
   dom_vec_t  dom_rst_n;
   logic      boot_req;

   rsc_kind_enc u_enc (
      .req_por   (req_por),
      .req_full  (req_full),
      .req_cfg   (req_cfg),
      .cfg_soft  (cfg_soft),
      .req_local (req_local),
      .kind      (kind),
      .dom_req   (dom_req),
      .boot_req  (boot_req)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      rsc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .clr     (dom_req[d]),
         .rst_n_o (dom_rst_n[d])
      );
   end

   assign rst_core_n   = dom_rst_n[DOM_CORE];
   assign rst_periph_n = dom_rst_n[DOM_PERIPH];
   assign rst_mmr_n    = dom_rst_n[DOM_MMR];
   assign rst_dbg_n    = dom_rst_n[DOM_DBG];
   assign rst_iso_n    = dom_rst_n[DOM_ISO];

   rsc_boot_seq u_boot (
      .clk        (clk),
      .boot_req   (boot_req),
      .core_req   (dom_req[DOM_CORE]),
      .core_rst_n (dom_rst_n[DOM_CORE]),
      .boot_start (boot_start)
   );

   // the isolated domain is cleared exactly by the strap-latching kinds
   rsc_strap #(
      .STRAP_W (STRAP_W), .DEV_W (DEV_W), .CFG_W (CFG_W),
      .XTRA_W  (XTRA_W),  .EXT_A (EXT_A), .EXT_B (EXT_B)
   ) u_strap (
      .clk    (clk),
      .cap_n  (dom_rst_n[DOM_ISO]),
      .pins   (strap_pins),
      .word   (strap_word),
      .dev    (boot_dev),
      .dev_oh (boot_dev_oh),
      .cfg    (dev_cfg),
      .pll    (pll_sel),
      .ext    (ext_cfg),
      .bypass (pll_bypass)
   );

endmodule

// File: rtl/rst_strap_ctrl_chk.sv
module rst_strap_ctrl_chk #(
   parameter int STRAP_W = 13,
   parameter int DEV_W   = 3
) (
   input logic                  clk,
   input logic                  req_por,
   input logic                  req_full,
   input logic                  req_cfg,
   input logic                  cfg_soft,
   input logic                  req_local,
   input logic                  rst_core_n,
   input logic                  rst_mmr_n,
   input logic                  rst_dbg_n,
   input logic                  rst_iso_n,
   input logic                  boot_start,
   input logic [STRAP_W-1:0]    strap_word,
   input logic [DEV_W-1:0]      boot_dev,
   input logic [(1<<DEV_W)-1:0] boot_dev_oh
);

   // R6: any request holds the core in reset without waiting for a clock
   p_core_held_r6: assert property (@(posedge clk) disable iff (req_por)
      (req_full || req_cfg || req_local) |-> !rst_core_n);

   // R3: debug domain only falls under a full (or power-on) request
   p_dbg_kept_r3: assert property (@(posedge clk) disable iff (req_por)
      $fell(rst_dbg_n) |-> (req_full || $past(req_full)));

   // R4: configuration-register domain never falls under a soft-only request
   p_mmr_soft_r4: assert property (@(posedge clk) disable iff (req_por)
      $fell(rst_mmr_n) |-> (req_full || $past(req_full) ||
                            (req_cfg && !cfg_soft) || $past(req_cfg && !cfg_soft)));

   // R7: boot pulse lasts one cycle
   p_boot_single_r7: assert property (@(posedge clk) disable iff (req_por)
      boot_start |=> !boot_start);

   // R7: boot pulse only once the core has been out of reset for a cycle
   p_boot_after_core_r7: assert property (@(posedge clk) disable iff (req_por)
      $rose(boot_start) |-> (rst_core_n && $past(rst_core_n)));

   // R11: strap word frozen outside the capture window
   p_strap_hold_r11: assert property (@(posedge clk) disable iff (req_por)
      $past(rst_iso_n) |-> $stable(strap_word));

   // R9: one-hot device matches the code
   p_dev_onehot_r9: assert property (@(posedge clk) disable iff (req_por)
      ($countones(boot_dev_oh) == 1) && boot_dev_oh[boot_dev]);

endmodule

bind rst_strap_ctrl rst_strap_ctrl_chk #(.STRAP_W(STRAP_W), .DEV_W(DEV_W)) u_chk (.*);

// File: tb/rst_strap_ctrl_test.sv
module rst_strap_ctrl_test;

   logic        clk = 1'b0;
   logic        req_por = 1'b1, req_full = 1'b0, req_cfg = 1'b0;
   logic        cfg_soft = 1'b0, req_local = 1'b0;
   logic [12:0] strap_pins = '0;
   logic        rst_core_n, rst_periph_n, rst_mmr_n, rst_dbg_n, rst_iso_n;
   logic        boot_start;
   logic [12:0] strap_word;
   logic [2:0]  boot_dev;
   logic [7:0]  boot_dev_oh;
   logic [6:0]  dev_cfg;
   logic [2:0]  pll_sel, ext_cfg;
   logic        pll_bypass;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      string       tag;
      string       rq;
      logic [4:0]  mask;
      int          boots;
      logic [12:0] strap;
   } exp_t;

   exp_t        sb_q[$];
   logic [12:0] strap_model = '0;

   always #2 clk = ~clk;

   rst_strap_ctrl uut (
      .clk(clk), .req_por(req_por), .req_full(req_full), .req_cfg(req_cfg),
      .cfg_soft(cfg_soft), .req_local(req_local), .strap_pins(strap_pins),
      .rst_core_n(rst_core_n), .rst_periph_n(rst_periph_n), .rst_mmr_n(rst_mmr_n),
      .rst_dbg_n(rst_dbg_n), .rst_iso_n(rst_iso_n), .boot_start(boot_start),
      .strap_word(strap_word), .boot_dev(boot_dev), .boot_dev_oh(boot_dev_oh),
      .dev_cfg(dev_cfg), .pll_sel(pll_sel), .ext_cfg(ext_cfg), .pll_bypass(pll_bypass)
   );

   task automatic check(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: act=%0h exp=%0h", rq, what, act, exp);
      end
   endtask

   // expected domain mask {iso,dbg,mmr,periph,core}
   function automatic logic [4:0] exp_mask(bit p, bit f, bit c, bit s, bit l);
      if (p || f)  return 5'b11111;
      if (c)       return s ? 5'b00011 : 5'b00111;
      if (l)       return 5'b00001;
      return 5'b00000;
   endfunction

   // ---------------- monitor ----------------
   logic [4:0] low_seen = '0;
   int boot_cnt = 0, gap_bad = 0, wide_bad = 0;
   int n = 0, rel_n = -100;
   logic prev_core = 1'b0, prev_boot = 1'b0;

   task automatic compare(exp_t e);
      logic [2:0] d;
      logic       byp;
      d   = e.strap[2:0];
      byp = (d == 3'd5) || (d == 3'd6);
      check(low_seen == e.mask, e.rq, {e.tag, " domain mask"}, 32'(low_seen), 32'(e.mask));
      check(boot_cnt == e.boots, (e.boots != 0) ? "R7" : e.rq, {e.tag, " boot pulses"},
            32'(boot_cnt), 32'(e.boots));
      check(gap_bad == 0 && wide_bad == 0, "R7", {e.tag, " boot pulse timing"},
            32'(gap_bad + wide_bad), 32'd0);
      check(strap_word == e.strap, e.rq, {e.tag, " strap word"}, 32'(strap_word), 32'(e.strap));
      check(boot_dev == d && dev_cfg == e.strap[9:3] && boot_dev_oh == (8'd1 << d),
            "R9", {e.tag, " field decode"}, {boot_dev_oh, 1'b0, dev_cfg, 5'd0, boot_dev},
            {(8'd1 << d), 1'b0, e.strap[9:3], 5'd0, d});
      check(pll_bypass == byp && pll_sel == (byp ? 3'd0 : e.strap[12:10]) &&
            ext_cfg == (byp ? e.strap[12:10] : 3'd0), "R10", {e.tag, " upper field"},
            {pll_bypass, 1'b0, pll_sel, 1'b0, ext_cfg},
            {byp, 1'b0, (byp ? 3'd0 : e.strap[12:10]), 1'b0, (byp ? e.strap[12:10] : 3'd0)});
      low_seen = '0;
      boot_cnt = 0;
      gap_bad  = 0;
      wide_bad = 0;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         #1;
         n++;
         low_seen |= ~{rst_iso_n, rst_dbg_n, rst_mmr_n, rst_periph_n, rst_core_n};
         if (!prev_core && rst_core_n) rel_n = n;
         if (boot_start) begin
            boot_cnt++;
            if (n - rel_n != 1) gap_bad++;
            if (prev_boot) wide_bad++;
         end
         prev_core = rst_core_n;
         prev_boot = boot_start;
         if (sb_q.size() != 0) compare(sb_q.pop_front());
      end
   end

   // ---------------- driver ----------------
   task automatic scen(string tag, string rq, bit p, bit f, bit c, bit s, bit l,
                       logic [12:0] pins);
      exp_t e;
      @(negedge clk);
      strap_pins = pins;
      cfg_soft   = s;
      req_por = p; req_full = f; req_cfg = c; req_local = l;
      #0.5;
      check(rst_core_n == 1'b0, "R6", {tag, " async assert"}, 32'(rst_core_n), 32'd0);
      repeat (4) @(negedge clk);
      req_por = 0; req_full = 0; req_cfg = 0; req_local = 0;
      @(posedge clk); #1;
      check(rst_core_n == 1'b0, "R6", {tag, " held after 1st edge"}, 32'(rst_core_n), 32'd0);
      @(posedge clk); #1;
      check(rst_core_n == 1'b1, "R6", {tag, " released on 2nd edge"}, 32'(rst_core_n), 32'd1);
      repeat (6) @(negedge clk);
      if (p || f) strap_model = pins;
      e.tag = tag; e.rq = rq; e.mask = exp_mask(p, f, c, s, l);
      e.boots = (p || f || c) ? 1 : 0; e.strap = strap_model;
      sb_q.push_back(e);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      exp_t e;
      // R1: reset state at time zero under power-on
      #1;
      check({rst_iso_n, rst_dbg_n, rst_mmr_n, rst_periph_n, rst_core_n} == 5'b0, "R1",
            "reset state domains", 32'({rst_iso_n, rst_dbg_n, rst_mmr_n, rst_periph_n, rst_core_n}), 32'd0);
      check(boot_start == 1'b0, "R1", "reset state boot", 32'(boot_start), 32'd0);
      req_por = 0;
      repeat (8) @(negedge clk);
      // drain the initial power-on pulse
      low_seen = '0; boot_cnt = 0; gap_bad = 0; wide_bad = 0;

      scen("por pcie", "R1", 1, 0, 0, 0, 0, 13'b101_0110011_100);

      // R11: pins move with no reset in progress
      @(negedge clk);
      strap_pins = 13'b010_1111000_011;
      repeat (5) @(negedge clk);
      e.tag = "idle pins"; e.rq = "R11"; e.mask = 5'b0; e.boots = 0; e.strap = strap_model;
      sb_q.push_back(e);
      repeat (3) @(negedge clk);

      scen("full i2c",      "R2", 0, 1, 0, 0, 0, 13'b011_1010101_101);
      scen("cfg hard",      "R3", 0, 0, 1, 0, 0, 13'b110_0001111_110);
      scen("cfg soft",      "R4", 0, 0, 1, 1, 0, 13'b001_1100011_001);
      scen("local",         "R5", 0, 0, 0, 0, 1, 13'b111_0000001_010);
      scen("soft+local",    "R8", 0, 0, 1, 1, 1, 13'b100_0101010_011);
      scen("full+cfg spi",  "R8", 0, 1, 1, 0, 0, 13'b110_1000001_110);

      // R8: power-on overlapped by a longer local request
      @(negedge clk);
      strap_pins = 13'b011_0011001_111;
      req_por = 1; req_local = 1;
      repeat (4) @(negedge clk);
      req_por = 0;
      repeat (8) @(negedge clk);
      check(rst_core_n == 1'b0 && boot_start == 1'b0, "R8", "core held by local, no boot yet",
            {30'd0, rst_core_n, boot_start}, 32'd0);
      check(rst_dbg_n == 1'b1, "R8", "debug released while local holds core",
            32'(rst_dbg_n), 32'd1);
      req_local = 0;
      repeat (8) @(negedge clk);
      strap_model = 13'b011_0011001_111;
      e.tag = "por+local"; e.rq = "R8"; e.mask = 5'b11111; e.boots = 1; e.strap = strap_model;
      sb_q.push_back(e);
      repeat (3) @(negedge clk);

      scen("por sleep", "R1", 1, 0, 0, 0, 0, 13'b100_1110000_000);

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R7", "scoreboard drained", 32'(sb_q.size()), 32'd0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL R7 watchdog expired: act=%0d exp=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule